// File: doc/BRIEF.md
# Bus cycle wait-state controller

This block decides how many bus-clock cycles each memory access lasts and counts them out. A requester presents an access with an area class, a chip-select index for external accesses and a flag saying whether the external bus runs in multiplexed mode. When the block is idle it accepts the request and latches the cycle length for that access. It then holds `busy` for that many cycles and pulses `cycle_done` on the last one.

The cycle length comes from a small register file written over an 8-bit port. A global wait bit stretches every area. Four per-chip-select bits, where 1 means fast, control external separate-bus accesses when the global bit is clear. The special-function area always takes two cycles, and multiplexed external accesses always take three. A guard register must have its bit 1 set before either mode register accepts a write. Bit 7 of the first mode register tri-states the bus-clock output pin through an output enable.

Top module: `bus_wait_ctrl`

## Requirements
- R1: An access with area code 0 (special-function area) lasts 2 cycles, whatever the register contents.
- R2: An access with area code 1 (internal memory) lasts 1 cycle when the global wait bit (bit 7 of the register at 0x05) is 0, and 2 cycles when it is 1.
- R3: With the global wait bit at 0, a separate-bus external access (area code 2 or 3, `req_mux`=0) to chip select n lasts 1 cycle when bit 4+n of the register at 0x08 is 1, and 2 cycles when that bit is 0.
- R4: With the global wait bit at 1, a separate-bus external access lasts 2 cycles regardless of the chip-select bits.
- R5: A multiplexed external access (`req_mux`=1) lasts 3 cycles, whatever the global wait bit and the chip-select bits.
- R6: After reset, all registers read 0, `busy` and `cycle_done` are 0, and `bclk_oe` is 1.
- R7: Writes to 0x04 and 0x05 change nothing unless bit 1 of the guard register (0x0A) is 1. The guard register can always be written, and it keeps its value after a write to a mode register.
- R8: `bclk_oe` is 0 while bit 7 of the register at 0x04 is 1, and 1 otherwise.
- R9: A request made while `busy` is high is ignored. The length of an access is fixed when it is accepted, so register writes made during the access do not change it.
- R10: `busy` rises in the cycle after a request is accepted. `cycle_done` is high for exactly one cycle, the last cycle of the access, and `busy` falls after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 8 | Register read data (combinational) |
| req | input | 1 | Access request |
| req_area | input | 2 | 0 special-function, 1 internal, 2 or 3 external |
| req_cs | input | 2 | Chip-select index for external accesses |
| req_mux | input | 1 | 1 selects multiplexed external bus |
| busy | output | 1 | An access is in progress |
| cycle_done | output | 1 | High on the final cycle of an access |
| bclk_oe | output | 1 | Output enable of the bus-clock pin |

## Verification
The hardest case to reach from the ports is an access whose settings change while it is still running. The length must come from the values latched at acceptance, and a request that arrives during the access must not start a second one. To reach this case, the stimulus sets the guard bit and the global wait bit, then starts a two-cycle internal access. In its first busy cycle the stimulus raises a multiplexed request and clears the wait bit, then withdraws the request before the access ends. The scoreboard then expects exactly two cycles, followed by an idle cycle.

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] MODE0_ADDR = 8'h04,
  parameter logic [AW-1:0] MODE1_ADDR = 8'h05,
  parameter logic [AW-1:0] CSCTL_ADDR = 8'h08,
  parameter logic [AW-1:0] GUARD_ADDR = 8'h0A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          req,
  input  logic [1:0]    req_area,
  input  logic [1:0]    req_cs,
  input  logic          req_mux,
  output logic          busy,
  output logic          cycle_done,
  output logic          bclk_oe
);
  localparam int CW = 2;

  logic [DW-1:0] mode0, mode1, cs_ctl, guard;
  logic [CW-1:0] cnt, len;
  logic          unlocked, accept, slow_all, cs_fast;

  assign unlocked = guard[1];
  assign slow_all = mode1[7];
  assign cs_fast  = cs_ctl[4 + req_cs];
  assign accept   = req && !busy;

  always_comb begin
    if (req_area == 2'd0)      len = CW'(2);
    else if (req_area == 2'd1) len = slow_all ? CW'(2) : CW'(1);
    else if (req_mux)          len = CW'(3);
    else if (slow_all)         len = CW'(2);
    else                       len = cs_fast ? CW'(1) : CW'(2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode0  <= '0;
      mode1  <= '0;
      cs_ctl <= '0;
      guard  <= '0;
    end else if (wr_en) begin
      if (wr_addr == MODE0_ADDR && unlocked) mode0 <= wr_data;
      if (wr_addr == MODE1_ADDR && unlocked) mode1 <= wr_data;
      if (wr_addr == CSCTL_ADDR)             cs_ctl <= wr_data;
      if (wr_addr == GUARD_ADDR)             guard <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= len;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) busy <= 1'b0;
    end
  end

  assign cycle_done = busy && (cnt == CW'(1));
  assign bclk_oe    = ~mode0[7];

  always_comb begin
    rd_data = '0;
    if (rd_addr == MODE0_ADDR)      rd_data = mode0;
    else if (rd_addr == MODE1_ADDR) rd_data = mode1;
    else if (rd_addr == CSCTL_ADDR) rd_data = cs_ctl;
    else if (rd_addr == GUARD_ADDR) rd_data = guard;
  end

  assert_sfr_two_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy && req_area == 2'd0) |=> (busy && cnt == CW'(2)));

  assert_mux_three_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy && req_area[1] && req_mux) |=> (busy && cnt == CW'(3)));

  assert_locked_mode1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == MODE1_ADDR && !guard[1]) |=> $stable(mode1));

  assert_locked_mode0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == MODE0_ADDR && !guard[1]) |=> $stable(bclk_oe));

  assert_hold_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cycle_done) |=> (busy && cnt == $past(cnt) - CW'(1)));

  assert_done_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> (!busy && !cycle_done));
endmodule

// File: tb/bus_wait_ctrl_test.sv
module bus_wait_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0] rd_data;
  logic       req = 1'b0;
  logic [1:0] req_area = '0, req_cs = '0;
  logic       req_mux = 1'b0;
  logic       busy, cycle_done, bclk_oe;

  int checks = 0, fails = 0;
  int exp_q[$];
  string tag_q[$];
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bus_wait_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .req(req), .req_area(req_area),
    .req_cs(req_cs), .req_mux(req_mux), .busy(busy), .cycle_done(cycle_done),
    .bclk_oe(bclk_oe)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, int exp);
    rd_addr = a;
    #1;
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic access(logic [1:0] area, logic [1:0] cs, logic mux, int exp, string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1'b1; req_area = area; req_cs = cs; req_mux = mux;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    req = 1'b0;
    while (busy) @(negedge clk);
  endtask

  int run = 0;
  bit prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) run++;
      if (cycle_done && prev_done) chk("R10 single pulse", 1, 0);
      if (cycle_done) begin
        if (exp_q.size() == 0) chk("R9 unexpected access", 1, 0);
        else begin
          string t;
          int e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, run, e);
        end
        run = 0;
      end
      prev_done = cycle_done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 busy", int'(busy), 0);
    chk("R6 done", int'(cycle_done), 0);
    chk("R6 bclk_oe", int'(bclk_oe), 1);
    rd_chk("R6 mode0", 8'h04, 0);
    rd_chk("R6 mode1", 8'h05, 0);
    rd_chk("R6 csctl", 8'h08, 0);
    rd_chk("R6 guard", 8'h0A, 0);

    access(2'd0, 2'd0, 1'b0, 2, "R1 sfr default");
    access(2'd1, 2'd0, 1'b0, 1, "R2 internal no wait");
    for (int i = 0; i < 4; i++) access(2'd2, 2'(i), 1'b0, 2, "R3 cs bit zero");
    access(2'd2, 2'd1, 1'b1, 3, "R5 mux no wait");

    wr(8'h05, 8'h80);
    rd_chk("R7 locked mode1", 8'h05, 0);
    wr(8'h04, 8'h80);
    chk("R7 locked mode0 oe", int'(bclk_oe), 1);
    wr(8'h0A, 8'h02);
    rd_chk("R7 guard write", 8'h0A, 2);
    wr(8'h05, 8'h80);
    rd_chk("R7 unlocked mode1", 8'h05, 8'h80);
    rd_chk("R7 guard kept", 8'h0A, 2);

    access(2'd1, 2'd0, 1'b0, 2, "R2 internal wait");
    access(2'd0, 2'd0, 1'b0, 2, "R1 sfr with wait");
    wr(8'h08, 8'hF0);
    access(2'd2, 2'd2, 1'b0, 2, "R4 global over cs");
    access(2'd3, 2'd0, 1'b0, 2, "R4 global area3");
    access(2'd2, 2'd3, 1'b1, 3, "R5 mux with wait");

    // R9: disturb a running 2-cycle internal access
    @(negedge clk);
    req = 1'b1; req_area = 2'd1; req_mux = 1'b0;
    exp_q.push_back(2); tag_q.push_back("R9 latched length");
    @(negedge clk);
    req_area = 2'd2; req_mux = 1'b1;
    wr_en = 1'b1; wr_addr = 8'h05; wr_data = 8'h00;
    @(negedge clk);
    req = 1'b0; wr_en = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R9 no second access", int'(busy), 0);
    rd_chk("R9 write landed", 8'h05, 0);

    wr(8'h08, 8'hA0);
    access(2'd2, 2'd0, 1'b0, 2, "R3 cs0 slow");
    access(2'd2, 2'd1, 1'b0, 1, "R3 cs1 fast");
    access(2'd3, 2'd2, 1'b0, 2, "R3 cs2 slow");
    access(2'd2, 2'd3, 1'b0, 1, "R3 cs3 fast");
    access(2'd2, 2'd1, 1'b1, 3, "R5 mux fast cs");

    wr(8'h04, 8'h80);
    @(negedge clk);
    chk("R8 pin floated", int'(bclk_oe), 0);
    wr(8'h04, 8'h00);
    @(negedge clk);
    chk("R8 pin driven", int'(bclk_oe), 1);
    wr(8'h0A, 8'h00);
    wr(8'h04, 8'h80);
    @(negedge clk);
    chk("R7 relocked mode0", int'(bclk_oe), 1);

    repeat (3) @(negedge clk);
    chk("R10 scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule